// File: doc/BRIEF.md
# UART Receive FIFO Trigger Controller

This block sits between a UART receive deserializer and the rest of the chip. Each received byte enters a 16-entry first-in first-out store. A small control register sets how full the store must become before the block asks for service. Service is requested either as a data-available interrupt or as a DMA request, and the control register chooses which one.

The control register is write-only. Its fields are a store enable, a one-shot flush command, a DMA routing select and a two-bit fill threshold code. The store is flushed whenever the enable changes value, in either direction. While the enable is low, the block accepts no bytes and raises no request.

A byte that arrives when the store is full is dropped, and a sticky overrun flag records the loss. The flush command clears this flag. The consumer reads bytes through a pop port that shows the oldest byte ahead of the pop.

Top module: `rxq_trigger_ctrl`

## Requirements
- R1: After reset, occupancy is 0, both request outputs and the overrun flag are low, and every control field is 0, so the store starts disabled.
- R2: Bytes leave through the pop port in the order they were accepted. `pop_data` shows the oldest byte before `pop_req` is applied. Each accepted push adds one to `occupancy` and each pop of a non-empty store subtracts one.
- R3: Control bits [7:6] select the fill threshold: 2'b00 means 1 byte, 2'b01 means 4, 2'b10 means 8 and 2'b11 means 14.
- R4: A request is active while the enable is 1 and `occupancy` is at or above the threshold. It goes low in the same cycle that a pop takes `occupancy` below the threshold.
- R5: When the enable is 1 and control bit 3 is 1, the request appears on `dma_req` and `irq_data_avail` stays low. When bit 3 is 0, the request appears on `irq_data_avail` and `dma_req` stays low.
- R6: A control write with bit 1 set empties the store and clears the overrun flag. The command takes effect only on the write that carries it. A later write with bit 1 clear and the same enable leaves the contents unchanged.
- R7: A control write that changes bit 0 (the enable), from 0 to 1 or from 1 to 0, empties the store. A write that keeps bit 0 unchanged does not empty the store.
- R8: While the enable is 0, pushes are ignored, and both request outputs are low even when bit 3 is 1.
- R9: A push into a full store (16 bytes) is discarded and sets `overrun`. The flag stays set until an R6 flush.
- R10: Control bits 2, 4 and 5 have no effect on the store, the requests or the threshold.
- R11: When a flush and a push occur in the same cycle, the flush wins and the store ends empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| push_vld | input | 1 | Received byte is valid this cycle |
| push_data | input | 8 | Received byte |
| pop_req | input | 1 | Remove the oldest byte |
| pop_data | output | 8 | Oldest byte in the store |
| occupancy | output | 5 | Number of bytes held |
| irq_data_avail | output | 1 | Data-available interrupt request |
| dma_req | output | 1 | DMA service request |
| overrun | output | 1 | Sticky byte-lost flag |

## Verification
The assertions assume that `cfg_wdata` matters only in a cycle where `cfg_wr` is high. They also assume that the full-store drop check is only meaningful in a cycle with no pop and no control write, so that property is written to require both conditions. The stimulus applies one operation per cycle, either a push, a pop or a control write, with one exception: the flush-versus-push cycle is deliberately overlapped to exercise R11. Pops are issued only while the bench's own model of the store holds bytes. Threshold boundaries are reached by filling the store one byte at a time.

// File: rtl/rxq_pkg.sv
// Shared definitions for the receive FIFO trigger controller.
// The bit positions match the control-register layout that the trigger
// logic and the flush logic decode.
package rxq_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic      enable;
        logic      dma_sel;
        trig_sel_e level;
    } rxq_cfg_t;

    localparam int unsigned CFG_BIT_EN    = 0;
    localparam int unsigned CFG_BIT_FLUSH = 1;
    localparam int unsigned CFG_BIT_DMA   = 3;
    localparam int unsigned CFG_LVL_LO    = 6;

    // Maps the threshold code to a byte count.
    function automatic int unsigned trig_threshold(trig_sel_e sel);
        case (sel)
            TRIG_ONE:   return 1;
            TRIG_FOUR:  return 4;
            TRIG_EIGHT: return 8;
            default:    return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_cfg_reg.sv
// Control register of the receive FIFO trigger controller.
// It holds the enable, the DMA select and the threshold code.
// In the cycle of a write it produces a flush pulse when the write either
// carries the flush command or changes the enable.
// Assumes: wdata is meaningful only while wr_en is high.
module rxq_cfg_reg
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output rxq_cfg_t   cfg,
    output logic       flush_store,
    output logic       flush_overrun
);

    logic enable_flip;
    logic flush_cmd;
    logic unused_wbits;

    // Capture the control fields on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.enable  <= wdata[CFG_BIT_EN];
            cfg.dma_sel <= wdata[CFG_BIT_DMA];
            cfg.level   <= trig_sel_e'(wdata[CFG_LVL_LO +: 2]);
        end
    end

    // Build the one-cycle flush pulses from the current write.
    always_comb begin
        enable_flip   = wr_en && (wdata[CFG_BIT_EN] != cfg.enable);
        flush_cmd     = wr_en && wdata[CFG_BIT_FLUSH];
        flush_store   = enable_flip || flush_cmd;
        flush_overrun = flush_cmd;
    end

    // Bits 2, 4 and 5 are accepted and discarded.
    assign unused_wbits = ^{wdata[2], wdata[5:4]};

endmodule

// File: rtl/rxq_fifo.sv
// Byte store with a show-ahead read port.
// A push into a full store is dropped and sets a sticky overrun flag.
// The flush input empties the store and takes priority over a push or a
// pop in the same cycle.
// Assumes: wr_en is already gated by the store enable.
module rxq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             ovr_clear,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count,
    output logic             overrun
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_nxt;
    logic [AW-1:0]    rd_nxt;
    logic             full;
    logic             accept;
    logic             take;

    // Select the pointer wrap logic from the depth.
    generate
        if (DEPTH == (1 << AW)) begin : g_pow2_wrap
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_cmp_wrap
            assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Decide which transfers happen this cycle.
    always_comb begin
        full   = (count == CW'(DEPTH));
        accept = wr_en && !full;
        take   = rd_en && (count != '0);
    end

    // Write an accepted byte into the storage.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance the pointers and the count; a flush restarts them.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) begin
                wr_ptr <= wr_nxt;
            end
            if (take) begin
                rd_ptr <= rd_nxt;
            end
            case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Keep the sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n || ovr_clear) begin
            overrun <= 1'b0;
        end else if (wr_en && full && !flush) begin
            overrun <= 1'b1;
        end
    end

    // Show the oldest byte.
    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/rxq_trigger.sv
// Compares the store occupancy with the selected threshold and routes
// the result to the interrupt output or to the DMA output.
// Purely combinational, so a request drops in the cycle the count falls.
// Assumes: DEPTH is at least the largest threshold (14).
module rxq_trigger
    import rxq_pkg::*;
#(
    parameter int CW = 5
) (
    input  rxq_cfg_t      cfg,
    input  logic [CW-1:0] count,
    output logic          irq_req,
    output logic          dma_req
);

    logic [CW-1:0] threshold;
    logic          level_hit;
    logic          dma_mode;

    // Compare the count with the threshold and route the result.
    always_comb begin
        threshold = CW'(trig_threshold(cfg.level));
        level_hit = cfg.enable && (count >= threshold);
        dma_mode  = cfg.enable && cfg.dma_sel;
        irq_req   = level_hit && !dma_mode;
        dma_req   = level_hit && dma_mode;
    end

endmodule

// File: rtl/rxq_trigger_ctrl.sv
// Top of the receive FIFO trigger controller.
// It connects the control register, the byte store and the trigger
// router. Pushes are admitted only while the store is enabled.
// Assumes: one deserializer byte per push_vld cycle.
module rxq_trigger_ctrl
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    input  logic              push_vld,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  occupancy,
    output logic              irq_data_avail,
    output logic              dma_req,
    output logic              overrun
);

    rxq_cfg_t cfg;
    logic     flush_store;
    logic     flush_overrun;
    logic     ctl_enable;
    logic     push_gated;

    // Gate the incoming push with the store enable.
    always_comb begin
        ctl_enable = cfg.enable;
        push_gated = push_vld && ctl_enable;
    end

    rxq_cfg_reg i_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (cfg_wr),
        .wdata         (cfg_wdata),
        .cfg           (cfg),
        .flush_store   (flush_store),
        .flush_overrun (flush_overrun)
    );

    rxq_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (DEPTH)
    ) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_store),
        .ovr_clear (flush_overrun),
        .wr_en     (push_gated),
        .wr_data   (push_data),
        .rd_en     (pop_req),
        .rd_data   (pop_data),
        .count     (occupancy),
        .overrun   (overrun)
    );

    rxq_trigger #(
        .CW (CNT_W)
    ) i_trig (
        .cfg     (cfg),
        .count   (occupancy),
        .irq_req (irq_data_avail),
        .dma_req (dma_req)
    );

endmodule

// File: rtl/rxq_trigger_ctrl_chk.sv
// Property checker for the receive FIFO trigger controller.
// It is attached to the top module with a bind statement.
module rxq_trigger_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [7:0]       cfg_wdata,
    input logic             push_vld,
    input logic             pop_req,
    input logic [CNT_W-1:0] occupancy,
    input logic             irq_data_avail,
    input logic             dma_req,
    input logic             overrun,
    input logic             ctl_enable
);

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH)); // R2
    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_data_avail && dma_req)); // R5
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0) |-> (!irq_data_avail && !dma_req)); // R4
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |-> (!irq_data_avail && !dma_req)); // R8
    AST_DISABLED_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_enable && !cfg_wr && push_vld) |=> (occupancy == '0)); // R8
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[1]) |=> (occupancy == '0 && !overrun)); // R6
    AST_EN_FLIP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_wdata[0] != ctl_enable)) |=> (occupancy == '0)); // R7
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == CNT_W'(DEPTH) && push_vld && !pop_req && !cfg_wr)
        |=> (occupancy == CNT_W'(DEPTH) && overrun)); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(cfg_wr && cfg_wdata[1])) |=> overrun); // R9

endmodule

bind rxq_trigger_ctrl rxq_trigger_ctrl_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) i_rxq_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_wdata      (cfg_wdata),
    .push_vld       (push_vld),
    .pop_req        (pop_req),
    .occupancy      (occupancy),
    .irq_data_avail (irq_data_avail),
    .dma_req        (dma_req),
    .overrun        (overrun),
    .ctl_enable     (ctl_enable)
);

// File: tb/test_rxq_trigger_ctrl.sv
// Scoreboard bench: the push driver queues expected bytes, and the pop
// monitor compares each byte the design presents against the queue.
module test_rxq_trigger_ctrl;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       push_vld = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic [4:0] occupancy;
    logic       irq_data_avail;
    logic       dma_req;
    logic       overrun;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    int   sb_q[$];
    bit   m_en = 1'b0;
    bit   m_dma = 1'b0;
    bit   m_ovr = 1'b0;
    int   m_lvl = 0;

    always #2.5 clk = ~clk;

    rxq_trigger_ctrl i_rxq_trigger_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr         (cfg_wr),
        .cfg_wdata      (cfg_wdata),
        .push_vld       (push_vld),
        .push_data      (push_data),
        .pop_req        (pop_req),
        .pop_data       (pop_data),
        .occupancy      (occupancy),
        .irq_data_avail (irq_data_avail),
        .dma_req        (dma_req),
        .overrun        (overrun)
    );

    function automatic int thr_of(int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(string req);
        bit hit;
        hit = m_en && (sb_q.size() >= thr_of(m_lvl));
        chk(req, "occupancy", int'(occupancy), sb_q.size());
        chk(req, "irq_data_avail", int'(irq_data_avail), int'(hit && !m_dma));
        chk(req, "dma_req", int'(dma_req), int'(hit && m_dma));
        chk(req, "overrun", int'(overrun), int'(m_ovr));
    endtask

    task automatic model_cfg(logic [7:0] v);
        if (v[1] || (v[0] != m_en)) sb_q.delete();
        if (v[1]) m_ovr = 1'b0;
        m_en  = v[0];
        m_dma = v[3];
        m_lvl = int'(v[7:6]);
    endtask

    task automatic cfg_write(logic [7:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        model_cfg(v);
    endtask

    task automatic push_byte(logic [7:0] b);
        push_vld = 1'b1;
        push_data = b;
        @(posedge clk); #1;
        push_vld = 1'b0;
        if (m_en) begin
            if (sb_q.size() < DEPTH) sb_q.push_back(int'(b));
            else m_ovr = 1'b1;
        end
    endtask

    task automatic pop_byte(string req);
        int exp;
        if (sb_q.size() == 0) return;
        exp = sb_q.pop_front();
        chk(req, "pop_data", int'(pop_data), exp);
        pop_req = 1'b1;
        @(posedge clk); #1;
        pop_req = 1'b0;
    endtask

    task automatic level_probe(int code);
        cfg_write(8'h03 | 8'(code << 6));
        for (int i = 0; i < thr_of(code) - 1; i++) push_byte(8'(8'h10 + i));
        check_state("R3");
        push_byte(8'hA5);
        check_state("R3");
        chk("R4", "request at threshold", int'(irq_data_avail), 1);
        pop_byte("R2");
        chk("R4", "request below threshold", int'(irq_data_avail), 0);
        check_state("R4");
        while (sb_q.size() > 0) pop_byte("R2");
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Main stimulus sequence.
    initial begin
        logic [15:0] lfsr;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        check_state("R1");

        for (int i = 0; i < 3; i++) push_byte(8'(i + 1));
        check_state("R8");

        cfg_write(8'h01);
        check_state("R7");

        for (int c = 0; c < 4; c++) level_probe(c);

        cfg_write(8'hC9);
        for (int i = 0; i < 14; i++) push_byte(8'(8'h40 + i));
        check_state("R5");
        chk("R5", "dma_req in dma mode", int'(dma_req), 1);
        chk("R5", "irq low in dma mode", int'(irq_data_avail), 0);

        for (int i = 0; i < 4; i++) push_byte(8'(8'h80 + i));
        check_state("R9");
        chk("R9", "occupancy at full", int'(occupancy), DEPTH);
        push_byte(8'hEE);
        check_state("R9");
        while (sb_q.size() > 0) pop_byte("R2");
        check_state("R9");
        chk("R9", "overrun sticky", int'(overrun), 1);

        for (int i = 0; i < 3; i++) push_byte(8'(8'h20 + i));
        cfg_write(8'hCB);
        check_state("R6");
        chk("R6", "overrun cleared", int'(overrun), 0);
        for (int i = 0; i < 3; i++) push_byte(8'(8'h30 + i));
        cfg_write(8'hC9);
        check_state("R6");
        chk("R6", "contents kept", int'(occupancy), 3);

        cfg_write(8'h35);
        check_state("R10");
        chk("R10", "ignored bits keep contents", int'(occupancy), 3);
        pop_byte("R10");

        cfg_write(8'h08);
        check_state("R7");
        for (int i = 0; i < 2; i++) push_byte(8'h55);
        check_state("R8");
        chk("R8", "dma ignored while disabled", int'(dma_req), 0);

        cfg_write(8'h09);
        push_byte(8'h66);
        check_state("R5");

        push_byte(8'h67);
        cfg_wr = 1'b1;
        cfg_wdata = 8'h0B;
        push_vld = 1'b1;
        push_data = 8'h68;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        push_vld = 1'b0;
        model_cfg(8'h0B);
        check_state("R11");

        cfg_write(8'h01);
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0] || sb_q.size() == 0) push_byte(lfsr[15:8]);
            else pop_byte("R2");
            if (i % 10 == 0) check_state("R2");
        end
        while (sb_q.size() > 0) pop_byte("R2");
        check_state("R2");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule